// File: doc/BRIEF.md
# Watchdog Timer with Sequence-Keyed Service

This block is a watchdog whose service write is not one fixed magic value but a rolling key. While the watchdog is disabled, software writes an 8-bit starting key (the seed) through the service port. After the watchdog is started, every service write must carry the value that a hidden 8-bit shift-register sequence generator currently holds. A correct write reloads the 16-bit down-counter and steps the generator. A wrong write, or the counter running down to zero, raises a one-cycle reset pulse.

The generator state is never visible at the ports, so software has to compute the sequence itself. A program that has lost track of its own flow is unlikely to produce the right next key. The step rule is: shift the key left by one bit, and if the bit that left bit 7 was a one, XOR the result with 0x63. This is the feedback polynomial x^8 + x^6 + x^5 + x + 1. Starting from seed 0xAA, the keys are 0xAA, 0x37, 0x6E, 0xDC and onward.

After a reset pulse the block returns to the disabled state, and the key goes back to the last seed written. It can be started again only by a new rising edge on the enable input. The asynchronous reset input is released through an internal two-stage synchronizer.

Top module: `key_watchdog`

## Requirements
- R1: After reset and for as long as the watchdog has not been started, `wd_rst_o` stays low whatever the counter load value.
- R2: While disabled, every service write stores its data as the new seed and key. The data is not compared and produces no pulse, and the last such write wins.
- R3: A rising edge of `en_i` sampled while disabled starts the watchdog and loads the counter with `load_i`. That clock edge produces no pulse.
- R4: If the watchdog is started, or last serviced, at clock edge E with load value L, and no service write follows, `wd_rst_o` is high after edge E+L+1 and low after every edge from E+1 to E+L. With L = 0 it is high after edge E+1.
- R5: A service write whose data equals the current key reloads the counter from `load_i`, advances the key and produces no pulse.
- R6: The key sequence follows the rule: shift left one bit, then XOR with 0x63 if the old bit 7 was one. From seed 0xAA the accepted writes are 0xAA, 0x37, 0x6E, 0xDC in that order.
- R7: While running, a service write whose data differs from the current key makes `wd_rst_o` high after that same clock edge, however far the counter is from zero.
- R8: With a seed of 0x00, the first service write after start produces the pulse after its edge, whatever its data, 0x00 included.
- R9: The pulse lasts exactly one cycle. Afterwards the watchdog is disabled and no further pulse occurs, and the key is the last seed again, so a restart without a new seed write expects the seed first.
- R10: When a correct service write arrives in the cycle in which the counter would expire, the service wins and no pulse occurs. A wrong write in that cycle gives a single one-cycle pulse.
- R11: Once running, the level of `en_i` has no effect. Dropping it does not stop the watchdog, and holding it high through a pulse does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Start request; a rising edge starts the watchdog while it is disabled |
| load_i | input | 16 | Counter reload value |
| clr_wr_i | input | 1 | Service write strobe |
| clr_data_i | input | 8 | Service write data (seed while disabled, key while running) |
| wd_rst_o | output | 1 | One-cycle reset pulse |

## Verification
Service acceptance and counter expiry can fall on the same clock edge: a service write issued exactly L cycles after the last reload lands on the edge where the counter would fire. The bench provokes this on purpose with directed gaps of exactly L, using both the correct key and a corrupted one. Its random phase also draws service gaps up to and including L. A correct key there must produce no pulse and restart the full window of L+1 edges. A wrong key must produce exactly one pulse that lasts one cycle.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;

  localparam int unsigned WDK_KEY_W   = 8;
  localparam int unsigned WDK_CNT_W   = 16;
  localparam logic [7:0]  WDK_TAPS    = 8'h63;

endpackage

// File: rtl/wdk_lfsr.sv
module wdk_lfsr #(
  parameter int unsigned       KEY_W = 8,
  parameter logic [KEY_W-1:0]  TAPS  = 8'h63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [KEY_W-1:0] load_val,
  input  logic             step_en,
  input  logic             restore_en,
  output logic [KEY_W-1:0] key_o
);

  logic [KEY_W-1:0] seed_q, seed_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [KEY_W-1:0] key_stepped;

  always_comb begin
    key_stepped = {key_q[KEY_W-2:0], 1'b0};
    if (key_q[KEY_W-1]) key_stepped = key_stepped ^ TAPS;
  end

  always_comb begin
    seed_d = seed_q;
    key_d  = key_q;
    if (restore_en) begin
      key_d = seed_q;
    end else if (load_en) begin
      seed_d = load_val;
      key_d  = load_val;
    end else if (step_en) begin
      key_d = key_stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      key_q  <= '0;
    end else begin
      seed_q <= seed_d;
      key_q  <= key_d;
    end
  end

  assign key_o = key_q;

  AST_KEY_BACK_TO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (key_q == seed_q)); // R9

  AST_STEP_STAYS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !restore_en && !load_en && key_q != '0) |=> (key_q != '0)); // R6

endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             dec_en,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_en) begin
      cnt_d = reload_val;
    end else if (dec_en && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  AST_RELOAD_TAKES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_en |=> (cnt_q == $past(reload_val))); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_en && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_wr_i,
  input  logic [KEY_W-1:0] clr_data_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             expired_i,
  output logic             seed_load_o,
  output logic             key_step_o,
  output logic             key_restore_o,
  output logic             cnt_reload_o,
  output logic             cnt_dec_o,
  output logic             wd_rst_o
);

  wd_state_e state_q, state_d;
  logic      en_q;
  logic      pulse_q;
  logic      running, arm, key_ok, key_bad, fire;

  always_comb begin
    running = (state_q == WD_RUN);
    arm     = !running && en_i && !en_q;
    key_ok  = running && clr_wr_i && (clr_data_i == key_i) && (key_i != '0);
    key_bad = running && clr_wr_i && !key_ok;
    fire    = key_bad || (running && expired_i && !key_ok);

    seed_load_o   = !running && clr_wr_i;
    key_step_o    = key_ok;
    key_restore_o = fire;
    cnt_reload_o  = arm || key_ok;
    cnt_dec_o     = running;

    state_d = state_q;
    if (fire)     state_d = WD_IDLE;
    else if (arm) state_d = WD_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_i;
      pulse_q <= fire;
    end
  end

  assign wd_rst_o = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE) |=> !pulse_q); // R2

  AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && clr_wr_i && clr_data_i != key_i) |=> pulse_q); // R7

  AST_ZERO_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && clr_wr_i && key_i == '0) |=> pulse_q); // R8

  AST_EXPIRY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && expired_i && !clr_wr_i) |=> pulse_q); // R4

  AST_GOOD_KEY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && clr_wr_i && clr_data_i == key_i && key_i != '0) |=> !pulse_q); // R10

  AST_PULSE_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (state_q == WD_IDLE)); // R9

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdk_pkg::*;
#(
  parameter int unsigned            CNT_W = WDK_CNT_W,
  parameter int unsigned            KEY_W = WDK_KEY_W,
  parameter logic [KEY_W-1:0]       TAPS  = WDK_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             clr_wr_i,
  input  logic [KEY_W-1:0] clr_data_i,
  output logic             wd_rst_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic [KEY_W-1:0] key;
  logic             expired;
  logic             seed_load, key_step, key_restore, cnt_reload, cnt_dec;

  wdk_ctrl #(.KEY_W(KEY_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .en_i          (en_i),
    .clr_wr_i      (clr_wr_i),
    .clr_data_i    (clr_data_i),
    .key_i         (key),
    .expired_i     (expired),
    .seed_load_o   (seed_load),
    .key_step_o    (key_step),
    .key_restore_o (key_restore),
    .cnt_reload_o  (cnt_reload),
    .cnt_dec_o     (cnt_dec),
    .wd_rst_o      (wd_rst_o)
  );

  wdk_lfsr #(.KEY_W(KEY_W), .TAPS(TAPS)) i_lfsr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_en    (seed_load),
    .load_val   (clr_data_i),
    .step_en    (key_step),
    .restore_en (key_restore),
    .key_o      (key)
  );

  wdk_count #(.CNT_W(CNT_W)) i_count (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reload_en  (cnt_reload),
    .reload_val (load_i),
    .dec_en     (cnt_dec),
    .expired_o  (expired)
  );

endmodule

// File: tb/test_key_watchdog.sv
module test_key_watchdog;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        en_i;
  logic [15:0] load_i;
  logic        clr_wr_i;
  logic [7:0]  clr_data_i;
  logic        wd_rst_o;

  int errors = 0;
  int checks = 0;

  key_watchdog i_key_watchdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .load_i     (load_i),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .wd_rst_o   (wd_rst_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] next_key(input logic [7:0] k);
    logic [7:0] r;
    r = {k[6:0], 1'b0};
    if (k[7]) r = r ^ 8'h63;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rst(input logic exp, input string req);
    check(wd_rst_o === exp, req, int'(wd_rst_o), int'(exp));
  endtask

  task automatic run_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      expect_rst(1'b0, req);
    end
  endtask

  task automatic write_clr(input logic [7:0] d, input logic exp, input string req);
    clr_wr_i   = 1'b1;
    clr_data_i = d;
    tick();
    clr_wr_i   = 1'b0;
    expect_rst(exp, req);
  endtask

  task automatic arm();
    en_i = 1'b1;
    tick();
    en_i = 1'b0;
    expect_rst(1'b0, "R3");
  endtask

  task automatic expire_chk(input int n, input string req);
    run_idle(n, req);
    tick();
    expect_rst(1'b1, req);
    tick();
    expect_rst(1'b0, "R9");
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] bkey;
    logic [7:0] bseed;
    void'($urandom(32'h1234_5EED));
    rst_n = 1'b0; en_i = 1'b0; load_i = 16'd5; clr_wr_i = 1'b0; clr_data_i = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    expect_rst(1'b0, "R1");
    run_idle(40, "R1");

    // R2 / R6 / R7: seed overwrite, stated sequence, wrong key
    load_i = 16'd10;
    write_clr(8'h11, 1'b0, "R2");
    write_clr(8'hAA, 1'b0, "R2");
    arm();
    write_clr(8'hAA, 1'b0, "R6");
    write_clr(8'h37, 1'b0, "R6");
    write_clr(8'h6E, 1'b0, "R6");
    write_clr(8'h66, 1'b1, "R7");
    tick(); expect_rst(1'b0, "R9");
    run_idle(25, "R9");

    // R9: restart without new seed expects seed first; R5 reload window
    arm();
    write_clr(8'hAA, 1'b0, "R9");
    expire_chk(10, "R5");

    // R4: plain expiry and zero load
    arm();
    expire_chk(10, "R4");
    load_i = 16'd0;
    arm();
    tick(); expect_rst(1'b1, "R4");
    tick(); expect_rst(1'b0, "R9");

    // R8: zero seed
    load_i = 16'd20;
    write_clr(8'h00, 1'b0, "R2");
    arm();
    write_clr(8'h00, 1'b1, "R8");
    tick(); expect_rst(1'b0, "R9");
    arm();
    run_idle(3, "R8");
    write_clr(8'h5A, 1'b1, "R8");
    tick();

    // R10: service on the expiry edge
    load_i = 16'd5;
    write_clr(8'h5C, 1'b0, "R2");
    arm();
    run_idle(5, "R10");
    write_clr(8'h5C, 1'b0, "R10");
    expire_chk(5, "R10");
    arm();
    run_idle(5, "R10");
    write_clr(8'h5D, 1'b1, "R10");
    tick(); expect_rst(1'b0, "R10");

    // R11: enable level ignored while running and through the pulse
    en_i = 1'b1;
    tick(); expect_rst(1'b0, "R3");
    run_idle(5, "R11");
    tick(); expect_rst(1'b1, "R11");
    run_idle(15, "R11");
    en_i = 1'b0;
    tick();

    // Random phase
    bseed = 8'h5C;
    for (int it = 0; it < 40; it++) begin
      int lval;
      int nclr;
      if (it % 4 != 0) begin
        bseed = 8'(1 + ($urandom % 255));
        write_clr(bseed, 1'b0, "R2");
      end
      lval = 1 + int'($urandom % 24);
      load_i = 16'(lval);
      arm();
      bkey = bseed;
      nclr = int'($urandom % 5);
      for (int j = 0; j < nclr; j++) begin
        run_idle(int'($urandom % (lval + 1)), "R5");
        write_clr(bkey, 1'b0, "R5");
        bkey = next_key(bkey);
      end
      if ($urandom % 2 == 0) begin
        expire_chk(lval, "R4");
      end else begin
        run_idle(int'($urandom % (lval + 1)), "R5");
        write_clr(bkey ^ 8'(1 + ($urandom % 255)), 1'b1, "R7");
        tick(); expect_rst(1'b0, "R9");
      end
      run_idle(2, "R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule